// File: doc/BRIEF.md
# Dual-Mode Converter Bus Interface Controller

This block is the timing and control logic between a microprocessor bus and an 8-bit conversion engine. It serves two bus protocols and selects between them with a mode input. In read-only mode, a single read access both starts a conversion and returns its result. In write-then-read mode, a write access starts the conversion. The result then enters the output latch at the first of two events: an internal timeout expires, or the bus reads early.

All bus strobes are brought into the clock domain through a two-flop synchroniser before their edges are detected. The conversion engine sits outside the block. It receives a one-cycle start pulse and answers with a one-cycle done pulse that carries a code and an overflow flag. The pads are also outside the block. The controller drives the data pad value and its output enable. It drives the ready line as an open-drain pull-down request and the interrupt as an active-low level. The mode pad carries a weak pull-down, so an undriven mode input selects read-only mode.

Top module: `cvt_bus_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `int_n` is 1, `rdy_pull` is 0, `conv_start` is 0 and `ovf_out` is 0. While `cs_n` is high, `db_oe` is 0.
- R2: The protocol is chosen from the synchronised `mode` level while the controller is idle. Mode 0 selects read-only. Mode 1 selects write-then-read.
- R3: In write-then-read mode, a falling `wr_n` while `cs_n` is low issues exactly one single-cycle `conv_start`. A falling `wr_n` while `cs_n` is high issues none.
- R4: In write-then-read mode with no early read, the result is latched and `int_n` goes to 0 when `TMO_CYC` cycles have passed after the synchronised rising edge of `wr_n`. From the `wr_n` pin change to `int_n` low takes `TMO_CYC`+3 cycles.
- R5: In write-then-read mode, a falling `rd_n` (with `cs_n` low) before the timeout latches the result. This happens at once if the engine has already finished, and otherwise at the engine's done pulse. `int_n` then goes low, and the timeout that follows does not latch again.
- R6: `int_n` returns to 1 on the synchronised rising edge of either `rd_n` or `cs_n`.
- R7: In read-only mode, a falling `rd_n` while `cs_n` is low issues one `conv_start`. The result is latched after the engine reports done. `int_n` falls in the same cycle in which `rdy_pull` is released.
- R8: In read-only mode, `rdy_pull` becomes 1 after `cs_n` falls while idle. It stays 1 until the result is latched. In write-then-read mode, `rdy_pull` stays 0.
- R9: `db_oe` is 1 only while `cs_n` and `rd_n` are both low. In read-only mode it also requires that a result has been latched and `int_n` is 0. When `db_oe` is 1, `db_out` carries the latched code.
- R10: A start strobe that arrives while a conversion is in progress is ignored. No second `conv_start` is issued, and the code that is latched is the one returned for the first start.
- R11: `ovf_out` takes the engine's overflow flag into the output latch together with the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| mode | input | 1 | Protocol select: 0 read-only, 1 write-then-read |
| conv_start | output | 1 | One-cycle start pulse to the conversion engine |
| conv_done | input | 1 | One-cycle done pulse from the engine |
| conv_code | input | DATA_W | Engine result, valid with conv_done |
| conv_ovf | input | 1 | Engine overflow flag, valid with conv_done |
| db_out | output | DATA_W | Latched code toward the data pads |
| db_oe | output | 1 | Data pad output enable (0 = high impedance) |
| rdy_pull | output | 1 | Ready pad pull-down request (0 = released, high impedance) |
| int_n | output | 1 | Conversion-complete interrupt, active low |
| ovf_out | output | 1 | Latched overflow flag |

## Verification
Each protocol is run with several codes and overflow values. Write-then-read conversions are run with and without an early read. These runs separate latching by the timeout from latching by the read strobe, and an early read made before the engine finishes shows that the latch waits for the done pulse. Clearing the interrupt is tried with both a read release and a chip-select release, which shows that either edge alone clears it. Further patterns strobe write with the chip deselected, hold read low with chip select high, and repeat a write strobe during a conversion. These show that a stray or repeated strobe neither starts a conversion nor drives the bus.

// File: rtl/cvt_bus_pkg.sv
// Package: shared types and strobe indices for the converter bus controller.
// Assumes: strobes are sampled as one vector in the index order below.
package cvt_bus_pkg;

    localparam int STROBE_N = 4;
    localparam int IDX_CS   = 0;
    localparam int IDX_WR   = 1;
    localparam int IDX_RD   = 2;
    localparam int IDX_MODE = 3;

    // Reset level of each synchroniser chain: strobes idle high, mode idles low.
    localparam logic [STROBE_N-1:0] STROBE_RST = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LOW,
        ST_WR_WAIT,
        ST_WR_PEND,
        ST_RD_CONV
    } cvt_state_e;

endpackage

// File: rtl/cvt_sync.sv
// Module: cvt_sync
// Brings N asynchronous pins into the clock domain through STAGES flops each,
// then reports the level and one-cycle rise and fall flags of the synced value.
// Assumes: STAGES >= 2; RST_VAL gives the idle level of each pin.
module cvt_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES:0] chain;

            // Shift the pin through the synchroniser plus one history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {(STAGES+1){RST_VAL[i]}};
                else        chain <= {chain[STAGES-1:0], pin[i]};
            end

            assign lvl[i]  = chain[STAGES-1];
            assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
            assign fall[i] = ~chain[STAGES-1] & chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/cvt_timer.sv
// Module: cvt_timer
// Counts cycles while run is high and flags the cycle in which the count
// reaches CYC-1. The count clears whenever run is low.
// Assumes: CYC >= 2.
module cvt_timer #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // Advance while running; rest at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expire)   cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == CW'(CYC - 1));

endmodule

// File: rtl/cvt_fsm.sv
// Module: cvt_fsm
// Protocol sequencer: issues engine starts, holds the engine result, moves it
// into the output latch, and drives the interrupt and ready requests.
// Assumes: all strobe inputs are already synchronised with edge flags.
module cvt_fsm
    import cvt_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              mode_s,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              wr_fall,
    input  logic              wr_rise,
    input  logic              rd_fall,
    input  logic              rd_rise,
    input  logic              tmo,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_code,
    input  logic              conv_ovf,
    output logic              timer_run,
    output logic              conv_start,
    output logic              int_n,
    output logic              rdy_pull,
    output logic [DATA_W-1:0] res_code,
    output logic              res_ovf
);

    cvt_state_e        state, nxt;
    logic              start_c, latch_c, set_rdy;
    logic              res_rdy, start_q, int_q, rdy_q;
    logic [DATA_W-1:0] hold_code, out_code;
    logic              hold_ovf, out_ovf;

    // Next-state, start and latch decisions.
    always_comb begin
        nxt       = state;
        start_c   = 1'b0;
        latch_c   = 1'b0;
        timer_run = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!cs_s && mode_s && wr_fall) begin
                    start_c = 1'b1;
                    nxt     = ST_WR_LOW;
                end else if (!cs_s && !mode_s && rd_fall) begin
                    start_c = 1'b1;
                    nxt     = ST_RD_CONV;
                end
            end
            ST_WR_LOW: begin
                if (wr_rise) nxt = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                timer_run = 1'b1;
                if ((rd_fall && !cs_s) || tmo) begin
                    if (res_rdy) begin
                        latch_c = 1'b1;
                        nxt     = ST_IDLE;
                    end else begin
                        nxt = ST_WR_PEND;
                    end
                end
            end
            ST_WR_PEND, ST_RD_CONV: begin
                if (res_rdy) begin
                    latch_c = 1'b1;
                    nxt     = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign set_rdy = (state == ST_IDLE) && !mode_s && cs_fall;

    // State, start pulse and engine result holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            start_q   <= 1'b0;
            res_rdy   <= 1'b0;
            hold_code <= '0;
            hold_ovf  <= 1'b0;
        end else begin
            state   <= nxt;
            start_q <= start_c;
            if (conv_done) begin
                res_rdy   <= 1'b1;
                hold_code <= conv_code;
                hold_ovf  <= conv_ovf;
            end else if (start_c) begin
                res_rdy <= 1'b0;
            end
        end
    end

    // Output latch, interrupt and ready request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code <= '0;
            out_ovf  <= 1'b0;
            int_q    <= 1'b1;
            rdy_q    <= 1'b0;
        end else if (latch_c) begin
            out_code <= hold_code;
            out_ovf  <= hold_ovf;
            int_q    <= 1'b0;
            rdy_q    <= 1'b0;
        end else begin
            if (rd_rise || cs_rise) int_q <= 1'b1;
            if (mode_s)             rdy_q <= 1'b0;
            else if (set_rdy)       rdy_q <= 1'b1;
        end
    end

    assign conv_start = start_q;
    assign int_n      = int_q;
    assign rdy_pull   = rdy_q;
    assign res_code   = out_code;
    assign res_ovf    = out_ovf;

endmodule

// File: rtl/cvt_bus_ctrl.sv
// Module: cvt_bus_ctrl (top)
// Converter bus interface controller. It synchronises the bus strobes, times
// the write-then-read window and sequences conversions in either protocol.
// Assumes: pads are outside; db_oe and rdy_pull are pad enables.
module cvt_bus_ctrl
    import cvt_bus_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TMO_CYC     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              mode,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_code,
    input  logic              conv_ovf,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              rdy_pull,
    output logic              int_n,
    output logic              ovf_out
);

    logic [STROBE_N-1:0] pins, lvl, rise, fall;
    logic                tmo, timer_run;

    assign pins[IDX_CS]   = cs_n;
    assign pins[IDX_WR]   = wr_n;
    assign pins[IDX_RD]   = rd_n;
    assign pins[IDX_MODE] = mode;

    cvt_sync #(
        .N      (STROBE_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(STROBE_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pins),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    cvt_timer #(
        .CYC(TMO_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .expire(tmo)
    );

    cvt_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (lvl[IDX_CS]),
        .mode_s    (lvl[IDX_MODE]),
        .cs_fall   (fall[IDX_CS]),
        .cs_rise   (rise[IDX_CS]),
        .wr_fall   (fall[IDX_WR]),
        .wr_rise   (rise[IDX_WR]),
        .rd_fall   (fall[IDX_RD]),
        .rd_rise   (rise[IDX_RD]),
        .tmo       (tmo),
        .conv_done (conv_done),
        .conv_code (conv_code),
        .conv_ovf  (conv_ovf),
        .timer_run (timer_run),
        .conv_start(conv_start),
        .int_n     (int_n),
        .rdy_pull  (rdy_pull),
        .res_code  (db_out),
        .res_ovf   (ovf_out)
    );

    // Pad enable: both strobes low; read-only mode also needs a latched result.
    assign db_oe = !cs_n && !rd_n && (lvl[IDX_MODE] || !int_n);

endmodule

// File: rtl/cvt_bus_ctrl_chk.sv
// Module: cvt_bus_ctrl_chk
// Protocol checker bound to cvt_bus_ctrl. It observes ports only and keeps its
// own record of whether the engine is busy.
module cvt_bus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rd_n,
    input logic conv_start,
    input logic conv_done,
    input logic db_oe,
    input logic rdy_pull,
    input logic int_n
);

    logic busy_ck;

    // Track the engine window from start pulse to done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_ck <= 1'b0;
        else if (conv_start) busy_ck <= 1'b1;
        else if (conv_done)  busy_ck <= 1'b0;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R3

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !busy_ck); // R10

    AST_READY_WITH_INT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_pull) |-> $fell(int_n)); // R7

    AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> (!cs_n && !rd_n)); // R9

    AST_INT_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> ($past(rd_n, 2) || $past(cs_n, 2))); // R6

endmodule

bind cvt_bus_ctrl cvt_bus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .conv_start(conv_start),
    .conv_done (conv_done),
    .db_oe     (db_oe),
    .rdy_pull  (rdy_pull),
    .int_n     (int_n)
);

// File: tb/cvt_bus_ctrl_tb_top.sv
// Bench for cvt_bus_ctrl: a behavioural engine stub, a vector table of
// conversions walked by one loop, then directed reset and corner tests.
module cvt_bus_ctrl_tb_top;

    localparam int DATA_W   = 8;
    localparam int TMO_CYC  = 64;
    localparam int CONV_CYC = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, mode = 1'b0;
    logic              conv_start, conv_done, conv_ovf;
    logic [DATA_W-1:0] conv_code, db_out;
    logic              db_oe, rdy_pull, int_n, ovf_out;

    int                n_chk = 0, n_fail = 0, n_start = 0;
    logic [DATA_W-1:0] stub_in = '0;
    logic              stub_ovf_in = 1'b0;
    int                stub_cnt = 0;

    always #4 clk = ~clk; // 125 MHz

    cvt_bus_ctrl #(.DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .mode(mode), .conv_start(conv_start), .conv_done(conv_done),
        .conv_code(conv_code), .conv_ovf(conv_ovf), .db_out(db_out),
        .db_oe(db_oe), .rdy_pull(rdy_pull), .int_n(int_n), .ovf_out(ovf_out)
    );

    // Engine stub: capture inputs at start, answer CONV_CYC cycles later.
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            stub_cnt  <= 0;
            conv_code <= '0;
            conv_ovf  <= 1'b0;
        end else if (conv_start) begin
            n_start   <= n_start + 1;
            stub_cnt  <= CONV_CYC;
            conv_code <= stub_in;
            conv_ovf  <= stub_ovf_in;
        end else if (stub_cnt > 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) conv_done <= 1'b1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write-then-read conversion; early selects read-strobe latching.
    task automatic wr_conv(input logic [7:0] code, input logic ovf,
                           input logic early, input logic clr_cs);
        int s0;
        stub_in = code; stub_ovf_in = ovf;
        mode = 1'b1; cs_n = 1'b0; cyc(4);
        s0 = n_start;
        wr_n = 1'b0; cyc(3); wr_n = 1'b1;
        if (early) begin
            cyc(20); rd_n = 1'b0; cyc(6);
            chk("R5 early int", int_n, 0);
        end else begin
            cyc(TMO_CYC + 5);
            chk("R4 timeout int", int_n, 0);
            rd_n = 1'b0; cyc(1);
        end
        chk("R3 one start", n_start - s0, 1);
        chk("R8 no ready in wr mode", rdy_pull, 0);
        chk("R9 oe on", db_oe, 1);
        chk("R9 data", db_out, code);
        chk("R11 ovf", ovf_out, ovf);
        if (clr_cs) begin
            cs_n = 1'b1; cyc(5);
            chk("R6 clear by cs", int_n, 1);
            chk("R9 oe off cs high", db_oe, 0);
            rd_n = 1'b1; cyc(2);
        end else begin
            rd_n = 1'b1; cyc(5);
            chk("R6 clear by rd", int_n, 1);
            cs_n = 1'b1; cyc(2);
        end
    endtask

    // Read-only conversion.
    task automatic rd_conv(input logic [7:0] code, input logic ovf, input logic clr_cs);
        stub_in = code; stub_ovf_in = ovf;
        mode = 1'b0; cyc(4);
        cs_n = 1'b0; cyc(5);
        chk("R8 ready pulled", rdy_pull, 1);
        rd_n = 1'b0; cyc(4);
        chk("R9 oe off during conv", db_oe, 0);
        chk("R7 int high during conv", int_n, 1);
        cyc(CONV_CYC + 6);
        chk("R7 int low", int_n, 0);
        chk("R7 ready released", rdy_pull, 0);
        chk("R2 rd-mode data", db_out, code);
        chk("R9 oe on", db_oe, 1);
        chk("R11 ovf", ovf_out, ovf);
        if (clr_cs) begin cs_n = 1'b1; cyc(5); chk("R6 clear by cs", int_n, 1); rd_n = 1'b1; end
        else        begin rd_n = 1'b1; cyc(5); chk("R6 clear by rd", int_n, 1); cs_n = 1'b1; end
        cyc(2);
    endtask

    // Vector: {mode, early, clr_cs, ovf, code[7:0]}
    localparam logic [11:0] VEC [8] = '{
        {4'b1100, 8'h5A}, {4'b1001, 8'hA3}, {4'b1011, 8'hFF}, {4'b1110, 8'h01},
        {4'b0000, 8'h3C}, {4'b0011, 8'hFF}, {4'b0010, 8'h80}, {4'b0000, 8'h00}
    };

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s0;
        cyc(4); rst_n = 1'b1; cyc(1);
        chk("R1 int", int_n, 1);
        chk("R1 rdy", rdy_pull, 0);
        chk("R1 start", conv_start, 0);
        chk("R1 oe", db_oe, 0);
        chk("R1 ovf", ovf_out, 0);

        foreach (VEC[i]) begin
            if (VEC[i][11]) wr_conv(VEC[i][7:0], VEC[i][8], VEC[i][10], VEC[i][9]);
            else            rd_conv(VEC[i][7:0], VEC[i][8], VEC[i][9]);
        end

        // R9: read low with chip select high never drives the bus.
        mode = 1'b1; rd_n = 1'b0; cyc(4);
        chk("R9 oe with cs high", db_oe, 0);
        rd_n = 1'b1; cyc(3);

        // R3: write strobe with chip deselected starts nothing.
        s0 = n_start;
        wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(TMO_CYC + 8);
        chk("R3 no start cs high", n_start - s0, 0);
        chk("R3 no int cs high", int_n, 1);

        // R4: exact timeout window after the write strobe rises.
        stub_in = 8'h6B; stub_ovf_in = 1'b0;
        cs_n = 1'b0; cyc(3);
        wr_n = 1'b0; cyc(3); wr_n = 1'b1;
        cyc(TMO_CYC + 1);
        chk("R4 int before timeout", int_n, 1);
        cyc(4);
        chk("R4 int after timeout", int_n, 0);
        cs_n = 1'b1; cyc(5);

        // R10: repeated write strobe during a conversion is ignored.
        s0 = n_start;
        stub_in = 8'h11; cs_n = 1'b0; cyc(3);
        wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(6);
        stub_in = 8'h22;
        wr_n = 1'b0; cyc(3); wr_n = 1'b1;
        cyc(TMO_CYC + 8);
        chk("R10 single start", n_start - s0, 1);
        rd_n = 1'b0; cyc(1);
        chk("R10 first code kept", db_out, 8'h11);
        rd_n = 1'b1; cs_n = 1'b1; cyc(5);

        // R5: early read before the engine finishes waits for done, no relatch.
        stub_in = 8'hC7; cs_n = 1'b0; cyc(3);
        wr_n = 1'b0; cyc(1); wr_n = 1'b1; cyc(1);
        rd_n = 1'b0; cyc(5);
        chk("R5 wait for engine", int_n, 1);
        cyc(CONV_CYC + 4);
        chk("R5 latched at done", int_n, 0);
        chk("R5 pend data", db_out, 8'hC7);
        rd_n = 1'b1; cyc(TMO_CYC + 10);
        chk("R5 no relatch at timeout", int_n, 1);
        cs_n = 1'b1; cyc(4);

        // R2: mode low again gives read-only behaviour (ready pulled).
        mode = 1'b0; cyc(4); cs_n = 1'b0; cyc(5);
        chk("R2 rd-mode ready", rdy_pull, 1);
        stub_in = 8'h9E; rd_n = 1'b0; cyc(CONV_CYC + 10);
        chk("R2 rd-mode result", db_out, 8'h9E);
        rd_n = 1'b1; cs_n = 1'b1; cyc(5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule